// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the sharer records for a small set of directory entries in a coherence controller. Instead of one presence bit per node, each entry holds a few node-ID pointers with a valid bit each, plus an overflow flag, a broadcast flag and a round-robin victim index. A command names an entry, a node and an operation. An add operation records the node as a sharer. A write operation returns the set of nodes that must be invalidated and then leaves the writer as the only sharer.

When an add finds every pointer in use, the entry follows the overflow policy on the `policy_i` input. The broadcast policy sets a sticky broadcast flag. The eviction policy displaces the pointer under the round-robin index and reports that node for invalidation. The coarse policy reuses the pointer bits as a group vector, with one bit per group of adjacent nodes. Every command is answered one cycle later by a `done_o` pulse that carries `inv_mask_o`, a mask with one bit per node. The policy is expected to stay constant between resets.

Top module: `sharer_dir`

## Requirements
- R1: Each accepted command (`cmd_valid_i` high at a clock edge) produces `done_o` high for exactly one cycle after that edge. `inv_mask_o` is all zero whenever `done_o` is low.
- R2: An add for a node that is already recorded, or an add to an entry that still has a free pointer, produces an all-zero mask. An add for a node that is already recorded does not change the entry.
- R3: In pointer mode, a write returns a mask with one bit set for each recorded sharer (bit n = node n), excluding the writer. The writer's bit is never set in a write mask under any policy.
- R4: After a write, the entry holds only the writer, in slot 0. The overflow flag, the broadcast flag and the victim index are cleared.
- R5: With policy 2'b00 (2'b11 behaves the same way), an add that finds all pointers full sets the broadcast flag and returns a zero mask. Later adds are ignored, and the next write invalidates every node except the writer.
- R6: With policy 2'b01, an add of a new node to a full entry replaces the pointer in the slot named by the victim index. The mask has exactly the displaced node's bit set, and the new node is never in it.
- R7: The victim index starts at slot 0 after reset or a write. It advances by one slot, wrapping to 0, after each eviction.
- R8: With policy 2'b10, an overflowing add turns the entry into a group vector. Group g covers nodes g*2 and g*2+1 in the default configuration. The groups of the stored nodes and of the new node are set, and later adds set their own group. A write invalidates every node of every set group, excluding the writer.
- R9: An add never invalidates more than one node. An add never invalidates anything under policies other than 2'b01.
- R10: A command changes only the entry it names.
- R11: After reset every entry is empty, so a write to any entry returns an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Overflow policy: 00 broadcast, 01 evict, 10 coarse vector, 11 broadcast |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_write_i | input | 1 | 1 = write (invalidate), 0 = add sharer |
| cmd_entry_i | input | $clog2(ENTRIES) | Entry selected by the command |
| cmd_node_i | input | $clog2(NODES) | Node ID of the requester |
| done_o | output | 1 | One-cycle completion pulse |
| inv_mask_o | output | NODES | Nodes to invalidate, valid with done_o |

## Verification
Two functions can meet in a single command. Under the eviction policy, one add both records the newcomer and reports the displaced node. Under the coarse policy, one add both converts the representation and records the node. The bench drives these cases directly by filling an entry and then adding a third distinct node. It also reaches them many times in random traffic over four entries. Each result is judged in the cycle of the `done_o` pulse: the mask must equal the model's victim or be zero, and the next write must reveal that the stored sharer set includes the newcomer.

// File: rtl/sharer_dir_pkg.sv
package sharer_dir_pkg;

    // Overflow handling selected at the block edge
    typedef enum logic [1:0] {
        POL_BCAST  = 2'b00,
        POL_EVICT  = 2'b01,
        POL_COARSE = 2'b10,
        POL_RSVD   = 2'b11
    } ovf_pol_e;

    typedef enum logic {
        OP_ADD   = 1'b0,
        OP_WRITE = 1'b1
    } dir_op_e;

endpackage

// File: rtl/sdir_mask_expand.sv
// Turns the stored form of one entry into a per-node sharer mask.
module sdir_mask_expand #(
    parameter int NODES = 16,
    parameter int NPTR  = 2,
    parameter int IDW   = 4,
    parameter int GRP   = 2
) (
    input  logic [NPTR-1:0][IDW-1:0] ptr_i,
    input  logic [NPTR-1:0]          vld_i,
    input  logic                     ovf_i,
    input  logic                     bcast_i,
    output logic [NODES-1:0]         sharers_o
);
    localparam int VBITS = NPTR * IDW;

    logic [VBITS-1:0] flat;
    logic [NODES-1:0] ptr_mask;
    logic [NODES-1:0] grp_mask;

    assign flat = ptr_i;

    // Each node maps onto the group bit that covers it
    for (genvar n = 0; n < NODES; n++) begin : g_grp
        assign grp_mask[n] = flat[n / GRP];
    end

    always_comb begin
        ptr_mask = '0;
        for (int p = 0; p < NPTR; p++) begin
            if (vld_i[p]) begin
                ptr_mask = ptr_mask | (NODES'(1) << ptr_i[p]);
            end
        end
    end

    always_comb begin
        if (bcast_i) begin
            sharers_o = '1;
        end else if (ovf_i) begin
            sharers_o = grp_mask;
        end else begin
            sharers_o = ptr_mask;
        end
    end

endmodule

// File: rtl/sdir_entry_next.sv
// Next-state and invalidation mask for the entry a command selects.
module sdir_entry_next
    import sharer_dir_pkg::*;
#(
    parameter int NODES = 16,
    parameter int NPTR  = 2,
    parameter int IDW   = 4,
    parameter int GRP   = 2,
    parameter int RRW   = 1
) (
    input  ovf_pol_e                 pol_i,
    input  dir_op_e                  op_i,
    input  logic [IDW-1:0]           node_i,
    input  logic [NODES-1:0]         sharers_i,
    input  logic [NPTR-1:0][IDW-1:0] ptr_q_i,
    input  logic [NPTR-1:0]          vld_q_i,
    input  logic                     ovf_q_i,
    input  logic                     bcast_q_i,
    input  logic [RRW-1:0]           rr_q_i,
    output logic [NPTR-1:0][IDW-1:0] ptr_d_o,
    output logic [NPTR-1:0]          vld_d_o,
    output logic                     ovf_d_o,
    output logic                     bcast_d_o,
    output logic [RRW-1:0]           rr_d_o,
    output logic [NODES-1:0]         inv_o
);
    localparam int VBITS = NPTR * IDW;

    logic             hit;
    logic             has_free;
    logic [RRW-1:0]   free_idx;
    logic [RRW-1:0]   rr_next;
    logic [VBITS-1:0] flat_q;
    logic [VBITS-1:0] node_grp;
    logic [VBITS-1:0] ptr_grps;
    logic [NODES-1:0] node_bit;

    assign flat_q   = ptr_q_i;
    assign node_bit = NODES'(1) << node_i;
    assign node_grp = VBITS'(1) << (node_i / GRP);
    assign has_free = ~&vld_q_i;
    assign rr_next  = (rr_q_i == RRW'(NPTR - 1)) ? '0 : rr_q_i + RRW'(1);

    // Match against live pointers and locate the lowest free slot
    always_comb begin
        hit      = 1'b0;
        free_idx = '0;
        ptr_grps = '0;
        for (int p = NPTR - 1; p >= 0; p--) begin
            if (!vld_q_i[p]) begin
                free_idx = RRW'(p);
            end
        end
        for (int p = 0; p < NPTR; p++) begin
            if (vld_q_i[p] && ptr_q_i[p] == node_i) begin
                hit = 1'b1;
            end
            if (vld_q_i[p]) begin
                ptr_grps = ptr_grps | (VBITS'(1) << (ptr_q_i[p] / GRP));
            end
        end
    end

    always_comb begin
        ptr_d_o   = ptr_q_i;
        vld_d_o   = vld_q_i;
        ovf_d_o   = ovf_q_i;
        bcast_d_o = bcast_q_i;
        rr_d_o    = rr_q_i;
        inv_o     = '0;

        if (op_i == OP_WRITE) begin
            inv_o      = sharers_i & ~node_bit;
            ptr_d_o    = '0;
            ptr_d_o[0] = node_i;
            vld_d_o    = '0;
            vld_d_o[0] = 1'b1;
            ovf_d_o    = 1'b0;
            bcast_d_o  = 1'b0;
            rr_d_o     = '0;
        end else if (bcast_q_i) begin
            // every node is already covered
        end else if (ovf_q_i) begin
            ptr_d_o = flat_q | node_grp;
        end else if (hit) begin
            // already recorded
        end else if (has_free) begin
            ptr_d_o[free_idx] = node_i;
            vld_d_o[free_idx] = 1'b1;
        end else begin
            unique case (pol_i)
                POL_EVICT: begin
                    inv_o           = NODES'(1) << ptr_q_i[rr_q_i];
                    ptr_d_o[rr_q_i] = node_i;
                    rr_d_o          = rr_next;
                end
                POL_COARSE: begin
                    ptr_d_o = ptr_grps | node_grp;
                    vld_d_o = '0;
                    ovf_d_o = 1'b1;
                end
                default: begin
                    ovf_d_o   = 1'b1;
                    bcast_d_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sharer_dir.sv
module sharer_dir
    import sharer_dir_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int NPTR    = 2,
    parameter int ENTRIES = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [1:0]                 policy_i,
    input  logic                       cmd_valid_i,
    input  logic                       cmd_write_i,
    input  logic [$clog2(ENTRIES)-1:0] cmd_entry_i,
    input  logic [$clog2(NODES)-1:0]   cmd_node_i,
    output logic                       done_o,
    output logic [NODES-1:0]           inv_mask_o
);
    localparam int IDW   = $clog2(NODES);
    localparam int VBITS = NPTR * IDW;
    localparam int GRP   = (NODES + VBITS - 1) / VBITS;
    localparam int RRW   = (NPTR > 1) ? $clog2(NPTR) : 1;

    typedef struct packed {
        logic [NPTR-1:0][IDW-1:0] ptr;
        logic [NPTR-1:0]          vld;
        logic                     ovf;
        logic                     bcast;
        logic [RRW-1:0]           rr;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 done;
        logic [NODES-1:0]     mask;
    } state_t;

    state_t           st_d, st_q;
    entry_t           sel_q, sel_d;
    logic [NODES-1:0] sharers;
    logic [NODES-1:0] nxt_inv;

    assign sel_q = st_q.ent[cmd_entry_i];

    sdir_mask_expand #(
        .NODES(NODES), .NPTR(NPTR), .IDW(IDW), .GRP(GRP)
    ) u_expand (
        .ptr_i    (sel_q.ptr),
        .vld_i    (sel_q.vld),
        .ovf_i    (sel_q.ovf),
        .bcast_i  (sel_q.bcast),
        .sharers_o(sharers)
    );

    sdir_entry_next #(
        .NODES(NODES), .NPTR(NPTR), .IDW(IDW), .GRP(GRP), .RRW(RRW)
    ) u_next (
        .pol_i    (ovf_pol_e'(policy_i)),
        .op_i     (dir_op_e'(cmd_write_i)),
        .node_i   (cmd_node_i),
        .sharers_i(sharers),
        .ptr_q_i  (sel_q.ptr),
        .vld_q_i  (sel_q.vld),
        .ovf_q_i  (sel_q.ovf),
        .bcast_q_i(sel_q.bcast),
        .rr_q_i   (sel_q.rr),
        .ptr_d_o  (sel_d.ptr),
        .vld_d_o  (sel_d.vld),
        .ovf_d_o  (sel_d.ovf),
        .bcast_d_o(sel_d.bcast),
        .rr_d_o   (sel_d.rr),
        .inv_o    (nxt_inv)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = cmd_valid_i;
        st_d.mask = '0;
        if (cmd_valid_i) begin
            st_d.mask             = nxt_inv;
            st_d.ent[cmd_entry_i] = sel_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = st_q.done;
    assign inv_mask_o = st_q.mask;

endmodule

// File: rtl/sharer_dir_chk.sv
module sharer_dir_chk #(
    parameter int NODES = 16,
    parameter int IDW   = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       policy_i,
    input logic             cmd_valid_i,
    input logic             cmd_write_i,
    input logic [IDW-1:0]   cmd_node_i,
    input logic             done_o,
    input logic [NODES-1:0] inv_mask_o
);
    AST_DONE_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_i |=> done_o); // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_valid_i |=> !done_o); // R1
    AST_MASK_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> inv_mask_o == '0); // R1
    AST_WRITER_SPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_write_i) |=> !inv_mask_o[$past(cmd_node_i)]); // R3
    AST_ADD_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !cmd_write_i) |=> $countones(inv_mask_o) <= 1); // R9
    AST_ADD_KEEPS_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !cmd_write_i) |=> !inv_mask_o[$past(cmd_node_i)]); // R6
    AST_ADD_QUIET_NONEVICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !cmd_write_i && policy_i != 2'b01) |=> inv_mask_o == '0); // R9
endmodule

bind sharer_dir sharer_dir_chk #(
    .NODES(NODES), .IDW(IDW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .policy_i   (policy_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .cmd_node_i (cmd_node_i),
    .done_o     (done_o),
    .inv_mask_o (inv_mask_o)
);

// File: tb/sharer_dir_test.sv
`timescale 1ns/1ps
module sharer_dir_test;
    localparam int NODES = 16;
    localparam int NPTR  = 2;
    localparam int ENT   = 4;
    localparam int GRP   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       policy = 2'b00;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [1:0]       cmd_entry = '0;
    logic [3:0]       cmd_node = '0;
    logic             done;
    logic [NODES-1:0] inv_mask;

    int n_checks = 0;
    int n_fail   = 0;

    // reference entry state
    int   m_ptr [ENT][NPTR];
    bit   m_vld [ENT][NPTR];
    bit   m_ovf [ENT];
    bit   m_bc  [ENT];
    bit [7:0] m_cv [ENT];
    int   m_rr  [ENT];

    always #2.5 clk = ~clk;

    sharer_dir #(.NODES(NODES), .NPTR(NPTR), .ENTRIES(ENT)) uut (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(policy),
        .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write),
        .cmd_entry_i(cmd_entry), .cmd_node_i(cmd_node),
        .done_o(done), .inv_mask_o(inv_mask)
    );

    function automatic logic [NODES-1:0] model_sharers(int e);
        logic [NODES-1:0] s = '0;
        if (m_bc[e]) return '1;
        if (m_ovf[e]) begin
            for (int i = 0; i < NODES; i++) if (m_cv[e][i / GRP]) s[i] = 1'b1;
            return s;
        end
        for (int p = 0; p < NPTR; p++) if (m_vld[e][p]) s[m_ptr[e][p]] = 1'b1;
        return s;
    endfunction

    function automatic logic [NODES-1:0] model_cmd(bit wr, int e, int n);
        logic [NODES-1:0] exp = '0;
        bit hit = 0;
        int free = -1;
        if (wr) begin
            exp = model_sharers(e) & ~(NODES'(1) << n);
            for (int p = 0; p < NPTR; p++) m_vld[e][p] = 0;
            m_ptr[e][0] = n; m_vld[e][0] = 1;
            m_ovf[e] = 0; m_bc[e] = 0; m_rr[e] = 0; m_cv[e] = '0;
            return exp;
        end
        if (m_bc[e]) return exp;
        if (m_ovf[e]) begin m_cv[e][n / GRP] = 1'b1; return exp; end
        for (int p = NPTR - 1; p >= 0; p--) begin
            if (m_vld[e][p] && m_ptr[e][p] == n) hit = 1;
            if (!m_vld[e][p]) free = p;
        end
        if (hit) return exp;
        if (free >= 0) begin m_ptr[e][free] = n; m_vld[e][free] = 1; return exp; end
        if (policy == 2'b01) begin
            exp = NODES'(1) << m_ptr[e][m_rr[e]];
            m_ptr[e][m_rr[e]] = n;
            m_rr[e] = (m_rr[e] + 1) % NPTR;
        end else if (policy == 2'b10) begin
            m_cv[e] = '0;
            for (int p = 0; p < NPTR; p++) m_cv[e][m_ptr[e][p] / GRP] = 1'b1;
            m_cv[e][n / GRP] = 1'b1;
            m_ovf[e] = 1;
        end else begin
            m_ovf[e] = 1; m_bc[e] = 1;
        end
        return exp;
    endfunction

    task automatic check(string req, string what, logic [NODES-1:0] act, logic [NODES-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic do_cmd(bit wr, int e, int n, string req);
        logic [NODES-1:0] exp;
        exp = model_cmd(wr, e, n);
        cmd_valid = 1'b1; cmd_write = wr;
        cmd_entry = 2'(e); cmd_node = 4'(n);
        @(posedge clk); @(negedge clk);
        check("R1", "done pulse", NODES'(done), NODES'(1));
        check(req, "inv mask", inv_mask, exp);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_check();
        cmd_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", "idle done", NODES'(done), '0);
        check("R1", "idle mask", inv_mask, '0);
    endtask

    task automatic do_reset(logic [1:0] pol);
        policy = pol;
        rst_n = 1'b0; cmd_valid = 1'b0;
        for (int e = 0; e < ENT; e++) begin
            for (int p = 0; p < NPTR; p++) begin m_vld[e][p] = 0; m_ptr[e][p] = 0; end
            m_ovf[e] = 0; m_bc[e] = 0; m_cv[e] = '0; m_rr[e] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic random_run(int count);
        string tag;
        for (int i = 0; i < count; i++) begin
            bit wr = ($urandom % 4) == 0;
            int e  = int'($urandom % ENT);
            int n  = int'($urandom % NODES);
            if (wr) tag = (policy == 2'b10) ? "R8" : (policy == 2'b01) ? "R3" : "R5";
            else    tag = (policy == 2'b01) ? "R6" : "R9";
            do_cmd(wr, e, n, tag);
            if (($urandom % 10) == 0) idle_check();
        end
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2718);
        @(negedge clk);

        // reset state and pointer mode
        do_reset(2'b00);
        check("R1", "reset done", NODES'(done), '0);
        for (int e = 0; e < ENT; e++) do_cmd(1, e, 3, "R11");
        do_cmd(0, 0, 5, "R2");
        do_cmd(0, 0, 5, "R2");
        do_cmd(1, 0, 9, "R3");
        do_cmd(1, 0, 10, "R4");
        // broadcast overflow
        do_cmd(0, 0, 1, "R2");
        do_cmd(0, 0, 2, "R5");
        do_cmd(0, 0, 6, "R9");
        do_cmd(1, 0, 4, "R5");
        idle_check();
        do_cmd(1, 1, 0, "R10");
        random_run(400);

        // eviction policy
        do_reset(2'b01);
        do_cmd(1, 1, 0, "R11");
        do_cmd(0, 1, 7, "R2");
        do_cmd(0, 1, 8, "R6");
        do_cmd(0, 1, 9, "R7");
        do_cmd(0, 1, 9, "R2");
        do_cmd(0, 1, 3, "R7");
        do_cmd(1, 1, 12, "R3");
        do_cmd(0, 1, 13, "R2");
        do_cmd(0, 1, 14, "R7");
        random_run(400);

        // coarse vector policy
        do_reset(2'b10);
        do_cmd(1, 2, 4, "R11");
        do_cmd(0, 2, 5, "R2");
        do_cmd(0, 2, 11, "R8");
        do_cmd(0, 2, 0, "R9");
        do_cmd(1, 3, 7, "R10");
        do_cmd(1, 2, 5, "R8");
        do_cmd(1, 2, 6, "R4");
        random_run(400);

        // reserved encoding acts as broadcast
        do_reset(2'b11);
        do_cmd(1, 0, 2, "R11");
        do_cmd(0, 0, 3, "R2");
        do_cmd(0, 0, 15, "R5");
        do_cmd(1, 0, 15, "R5");
        random_run(200);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule